// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Resolver

This block decides which pending maskable interrupt a processor core takes next. Each of `N` sources owns a pending bit, set by a one-cycle pulse, and a 3-bit priority level written by software. A combinational walk over the sources, in port-index order, keeps a running best level. A requesting source takes over only when its level is strictly above the best level seen so far, so an equal level never displaces an earlier source.

The resolved winner is compared with the processor priority level (`ps_ipl`) and the disable flag (`ps_i`), both held inside the block. An eligible winner is taken on the next clock edge. At that edge the block pulses the accept outputs and a save-status strobe, raises the disable flag, loads the processor level with the winner's level and drops the winner's pending bit.

Reset and watchdog requests bypass the flag and the level comparison. The core restores the status word through a write port, for example on return from a handler.

Top module: `irq_chain_arbiter`

## Requirements
- R1: Among pending sources, the one with the numerically highest level is accepted; `acc_idx` gives its port index in binary and `acc_lvl` gives its level.
- R2: When pending sources share the highest level, the one with the lowest port index is accepted.
- R3: A source whose level is 0 is never accepted, even with `ps_ipl` = 0 and `ps_i` = 0.
- R4: A winner is accepted only when its level is strictly greater than `ps_ipl`; an equal or lower level stays pending.
- R5: While `ps_i` = 1 no maskable source is accepted; the source stays pending and is taken once `ps_i` returns to 0.
- R6: On acceptance `save_ps` pulses in the same cycle as `acc_pulse`, `ps_i` becomes 1 and `ps_ipl` becomes the accepted level.
- R7: The accepted source's pending bit is cleared, so once the status is restored it is not accepted again without a new pulse.
- R8: Pending bits are set by a `src_pulse` bit or by a software write of 1 (`pend_we`, `pend_din` = 1). They are cleared by a software write of 0 or by acceptance. A clear and a set in the same cycle leave the bit cleared.
- R9: `wdt_req` is taken regardless of `ps_i` and `ps_ipl`: `wdt_take` and `save_ps` pulse, `ps_i` becomes 1, `ps_ipl` becomes 7, and no maskable source is accepted in that cycle.
- R10: `rst_req` outranks the watchdog and all other sources: `rst_take` pulses, `save_ps` stays 0, all pending bits clear, `ps_ipl` becomes 0 and `ps_i` becomes 1.
- R11: Each take output is a registered one-cycle pulse that appears at the first clock edge after its condition holds; a source pulsed at edge k, when otherwise eligible, is accepted at edge k+1.
- R12: After `rst_n` reset, every take output and strobe is 0, `ps_ipl` = 0, `ps_i` = 1, all levels are 0 and nothing is pending.
- R13: A status write (`st_we`) loads `ps_ipl` and `ps_i`, unless a take happens in the same cycle, in which case the take's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | N | One-cycle request pulses, one per source |
| lvl_we | input | 1 | Priority level write enable |
| lvl_sel | input | $clog2(N) | Source whose level is written |
| lvl_din | input | 3 | New priority level (0 disables) |
| pend_we | input | 1 | Software pending-bit write enable |
| pend_sel | input | $clog2(N) | Source whose pending bit is written |
| pend_din | input | 1 | Value written to the pending bit |
| st_we | input | 1 | Status restore enable |
| st_ipl | input | 3 | Processor priority level to restore |
| st_i | input | 1 | Disable flag to restore |
| wdt_req | input | 1 | Watchdog request, non-maskable |
| rst_req | input | 1 | Reset interrupt request, highest priority |
| acc_pulse | output | 1 | Maskable acceptance pulse |
| acc_idx | output | $clog2(N) | Index of the accepted source |
| acc_lvl | output | 3 | Level of the accepted source |
| save_ps | output | 1 | Strobe to push the status word |
| wdt_take | output | 1 | Watchdog acceptance pulse |
| rst_take | output | 1 | Reset acceptance pulse |
| ps_ipl | output | 3 | Current processor priority level |
| ps_i | output | 1 | Current interrupt disable flag |

## Verification
The bench targets equal-level ties, which a design using non-strict comparison would resolve toward the downstream source. It covers a winner whose level equals `ps_ipl`, which an off-by-one compare would accept, and level-0 sources while the processor level is 0, which a design without the enable rule would take. It also pulses a source in the same cycle its bit is cleared, where a set-wins merge would leave a phantom request. Random traffic mixes watchdog and reset requests with maskable pulses, so a design that lets a maskable acceptance slip through alongside them, or that re-accepts a source it has already served, shows up as a mismatch in the take pulses or the status word.

// File: rtl/irq_chain_arbiter.sv
module irq_chain_arbiter #(
  parameter int N  = 28,
  parameter int LW = 3,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_pulse,
  input  logic          lvl_we,
  input  logic [IW-1:0] lvl_sel,
  input  logic [LW-1:0] lvl_din,
  input  logic          pend_we,
  input  logic [IW-1:0] pend_sel,
  input  logic          pend_din,
  input  logic          st_we,
  input  logic [LW-1:0] st_ipl,
  input  logic          st_i,
  input  logic          wdt_req,
  input  logic          rst_req,
  output logic          acc_pulse,
  output logic [IW-1:0] acc_idx,
  output logic [LW-1:0] acc_lvl,
  output logic          save_ps,
  output logic          wdt_take,
  output logic          rst_take,
  output logic [LW-1:0] ps_ipl,
  output logic          ps_i
);

  logic [N-1:0]  pend;
  logic [LW-1:0] lvl [N];
  logic [LW-1:0] win_lvl;
  logic [IW-1:0] win_idx;

  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int k = 0; k < N; k++)
      if (pend[k] && lvl[k] > win_lvl) begin
        win_lvl = lvl[k];
        win_idx = IW'(k);
      end
  end

  wire take = (win_lvl > ps_ipl) && !ps_i && !wdt_req && !rst_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < N; k++) lvl[k] <= '0;
    end else if (lvl_we) begin
      for (int k = 0; k < N; k++)
        if (lvl_sel == IW'(k)) lvl[k] <= lvl_din;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else
      for (int k = 0; k < N; k++) begin
        if (rst_req || (take && win_idx == IW'(k)) ||
            (pend_we && pend_sel == IW'(k) && !pend_din))
          pend[k] <= 1'b0;
        else if (src_pulse[k] || (pend_we && pend_sel == IW'(k) && pend_din))
          pend[k] <= 1'b1;
      end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc_pulse <= 1'b0;
      acc_idx   <= '0;
      acc_lvl   <= '0;
      save_ps   <= 1'b0;
      wdt_take  <= 1'b0;
      rst_take  <= 1'b0;
      ps_ipl    <= '0;
      ps_i      <= 1'b1;
    end else begin
      acc_pulse <= 1'b0;
      save_ps   <= 1'b0;
      wdt_take  <= 1'b0;
      rst_take  <= 1'b0;
      if (rst_req) begin
        rst_take <= 1'b1;
        ps_i     <= 1'b1;
        ps_ipl   <= '0;
      end else if (wdt_req) begin
        wdt_take <= 1'b1;
        save_ps  <= 1'b1;
        ps_i     <= 1'b1;
        ps_ipl   <= '1;
      end else if (take) begin
        acc_pulse <= 1'b1;
        acc_idx   <= win_idx;
        acc_lvl   <= win_lvl;
        save_ps   <= 1'b1;
        ps_i      <= 1'b1;
        ps_ipl    <= win_lvl;
      end else if (st_we) begin
        ps_ipl <= st_ipl;
        ps_i   <= st_i;
      end
    end

endmodule

// File: rtl/irq_chain_arbiter_chk.sv
module irq_chain_arbiter_chk #(
  parameter int N  = 28,
  parameter int LW = 3,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  pend,
  input logic          acc_pulse,
  input logic [IW-1:0] acc_idx,
  input logic [LW-1:0] acc_lvl,
  input logic          save_ps,
  input logic          wdt_take,
  input logic          rst_take,
  input logic [LW-1:0] ps_ipl,
  input logic          ps_i
);

  AST_ONE_TAKE:     assert property (@(posedge clk) disable iff (!rst_n) $onehot0({acc_pulse, wdt_take, rst_take})); // R9
  AST_LVL_NONZERO:  assert property (@(posedge clk) disable iff (!rst_n) acc_pulse |-> acc_lvl != '0); // R3
  AST_BEAT_IPL:     assert property (@(posedge clk) disable iff (!rst_n) acc_pulse |-> acc_lvl > $past(ps_ipl)); // R4
  AST_I_BLOCKS:     assert property (@(posedge clk) disable iff (!rst_n) acc_pulse |-> !$past(ps_i)); // R5
  AST_ACC_STATUS:   assert property (@(posedge clk) disable iff (!rst_n) acc_pulse |-> save_ps && ps_i && ps_ipl == acc_lvl); // R6
  AST_ACC_CLEARED:  assert property (@(posedge clk) disable iff (!rst_n) acc_pulse |-> !pend[acc_idx]); // R7
  AST_WDT_STATUS:   assert property (@(posedge clk) disable iff (!rst_n) wdt_take |-> save_ps && ps_i && ps_ipl == '1); // R9
  AST_RST_STATUS:   assert property (@(posedge clk) disable iff (!rst_n) rst_take |-> !save_ps && ps_i && ps_ipl == '0 && pend == '0); // R10

endmodule

bind irq_chain_arbiter irq_chain_arbiter_chk #(.N(N), .LW(LW)) chk (
  .clk(clk), .rst_n(rst_n), .pend(pend), .acc_pulse(acc_pulse), .acc_idx(acc_idx),
  .acc_lvl(acc_lvl), .save_ps(save_ps), .wdt_take(wdt_take), .rst_take(rst_take),
  .ps_ipl(ps_ipl), .ps_i(ps_i)
);

// File: tb/irq_chain_arbiter_test.sv
module irq_chain_arbiter_test;
  localparam int N  = 28;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_pulse;
  logic lvl_we, pend_we, pend_din, st_we, st_i, wdt_req, rst_req;
  logic [IW-1:0] lvl_sel, pend_sel;
  logic [2:0] lvl_din, st_ipl;
  logic acc_pulse, save_ps, wdt_take, rst_take, ps_i;
  logic [IW-1:0] acc_idx;
  logic [2:0] acc_lvl, ps_ipl;

  irq_chain_arbiter #(.N(N)) uut (.*);

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [N-1:0] m_pend;
  logic [2:0] m_lvl [N];
  logic [2:0] m_ipl, e_lvl;
  logic m_i, e_acc, e_save, e_wdt, e_rst;
  logic [IW-1:0] e_idx;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    src_pulse = '0; lvl_we = 0; lvl_sel = '0; lvl_din = '0;
    pend_we = 0; pend_sel = '0; pend_din = 0;
    st_we = 0; st_ipl = '0; st_i = 0; wdt_req = 0; rst_req = 0;
  endtask

  task automatic cycle();
    logic [2:0] wl = '0;
    logic [IW-1:0] wi = '0;
    logic tk;
    for (int k = 0; k < N; k++)
      if (m_pend[k] && m_lvl[k] > wl) begin wl = m_lvl[k]; wi = IW'(k); end
    tk = (wl > m_ipl) && !m_i && !wdt_req && !rst_req;
    e_acc = 0; e_save = 0; e_wdt = 0; e_rst = 0;
    for (int k = 0; k < N; k++) begin
      if (rst_req || (tk && wi == IW'(k)) || (pend_we && pend_sel == IW'(k) && !pend_din))
        m_pend[k] = 0;
      else if (src_pulse[k] || (pend_we && pend_sel == IW'(k) && pend_din))
        m_pend[k] = 1;
    end
    if (rst_req) begin e_rst = 1; m_i = 1; m_ipl = 0; end
    else if (wdt_req) begin e_wdt = 1; e_save = 1; m_i = 1; m_ipl = 7; end
    else if (tk) begin e_acc = 1; e_idx = wi; e_lvl = wl; e_save = 1; m_i = 1; m_ipl = wl; end
    else if (st_we) begin m_ipl = st_ipl; m_i = st_i; end
    if (lvl_we && lvl_sel < N) m_lvl[lvl_sel] = lvl_din;
    @(posedge clk); @(negedge clk);
    chk("R11 acc_pulse", acc_pulse, e_acc);
    chk("R1 acc_idx", acc_idx, e_idx);
    chk("R1 acc_lvl", acc_lvl, e_lvl);
    chk("R6 save_ps", save_ps, e_save);
    chk("R9 wdt_take", wdt_take, e_wdt);
    chk("R10 rst_take", rst_take, e_rst);
    chk("R13 ps_ipl", ps_ipl, m_ipl);
    chk("R13 ps_i", ps_i, m_i);
    idle();
  endtask

  task automatic set_lvl(int s, int v);
    lvl_we = 1; lvl_sel = IW'(s); lvl_din = 3'(v); cycle();
  endtask

  task automatic restore(int ipl, bit i);
    st_we = 1; st_ipl = 3'(ipl); st_i = i; cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    m_pend = '0; m_ipl = 0; m_i = 1; e_idx = '0; e_lvl = '0;
    for (int k = 0; k < N; k++) m_lvl[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk("R12 acc_pulse", acc_pulse, 0);
    chk("R12 save_ps", save_ps, 0);
    chk("R12 ps_ipl", ps_ipl, 0);
    chk("R12 ps_i", ps_i, 1);

    // R2 tie and R3 level zero
    set_lvl(5, 3); set_lvl(9, 3); set_lvl(2, 0);
    st_we = 1; st_ipl = 0; st_i = 0;
    src_pulse = (N'(1) << 2) | (N'(1) << 5) | (N'(1) << 9);
    cycle();
    cycle();
    chk("R2 tie accept", acc_pulse, 1);
    chk("R2 tie upstream idx", acc_idx, 5);
    chk("R6 ipl loaded", ps_ipl, 3);
    restore(0, 0);
    cycle();
    chk("R7 next idx not repeated", acc_idx, 9);
    restore(0, 0);
    repeat (3) cycle();
    chk("R3 level zero ignored", acc_pulse, 0);

    // R4 level equal to IPL blocked
    set_lvl(7, 3);
    st_we = 1; st_ipl = 3; st_i = 0; src_pulse = N'(1) << 7;
    cycle();
    repeat (3) cycle();
    chk("R4 equal level held", acc_pulse, 0);
    restore(2, 0);
    cycle();
    chk("R4 higher than ipl accepted", acc_idx, 7);

    // R5 disable flag
    set_lvl(12, 5);
    restore(0, 1);
    src_pulse = N'(1) << 12;
    repeat (4) cycle();
    chk("R5 blocked while I=1", acc_pulse, 0);
    restore(0, 0);
    cycle();
    chk("R5 taken after I=0", acc_idx, 12);

    // R8 clear wins over same-cycle pulse
    set_lvl(11, 4);
    src_pulse = N'(1) << 11; pend_we = 1; pend_sel = 11; pend_din = 0;
    cycle();
    restore(0, 0);
    repeat (2) cycle();
    chk("R8 clear wins", acc_pulse, 0);
    pend_we = 1; pend_sel = 11; pend_din = 1;
    cycle();
    cycle();
    chk("R8 software set", acc_idx, 11);

    // R9 watchdog while disabled
    wdt_req = 1; cycle();
    chk("R9 wdt taken with I=1", wdt_take, 1);
    // R10 reset clears pending
    restore(0, 0);
    src_pulse = N'(1) << 12; cycle();
    rst_req = 1; wdt_req = 1; cycle();
    chk("R10 reset over wdt", rst_take, 1);
    restore(0, 0);
    repeat (2) cycle();
    chk("R10 pending cleared", acc_pulse, 0);

    // random traffic
    for (int t = 0; t < 4000; t++) begin
      for (int k = 0; k < N; k++) src_pulse[k] = ($urandom % 24) == 0;
      if ($urandom % 4 == 0) begin lvl_we = 1; lvl_sel = IW'($urandom % N); lvl_din = 3'($urandom); end
      if ($urandom % 8 == 0) begin pend_we = 1; pend_sel = IW'($urandom % N); pend_din = 1'($urandom); end
      if ($urandom % 3 == 0) begin st_we = 1; st_ipl = 3'($urandom % 5); st_i = ($urandom % 5) == 0; end
      wdt_req = ($urandom % 80) == 0;
      rst_req = ($urandom % 300) == 0;
      cycle();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule